// File: doc/BRIEF.md
# Stage-2 Permission Indirection Lookup

This block holds a 64-bit permission table made of sixteen 4-bit codes, loaded through a synchronous write port. A translation descriptor supplies a 4-bit index. The block picks the matching code and turns it into a set of access flags:

- read
- write
- unprivileged execute
- privileged execute
- a restricted-read marker
- two restricted-read qualifiers

The lookup path is combinational from the stored table.

A mechanism-enable input selects between the decoded table entry and a direct-permission bus that is passed straight through. While the mechanism is off, the table contents have no influence on the result. Every write to the table raises a one-cycle invalidate output, so that any cache holding decoded permissions can drop stale entries.

Top module: `s2_perm_lookup`

## Requirements
- R1: After reset the table holds all zeros, so every index decodes to all flags low while enabled, and `inval_pulse` is low.
- R2: Index m selects table bits [4m+3:4m]. The flag vector is `perm_out` = {tl1, tl0, mro, px, ux, wr, rd}, with rd at bit 0 and tl1 at bit 6.
- R3: Code 0000 (no access) drives all seven flags low. The reserved codes 0001 and 0101 behave identically to 0000.
- R4: Codes 0010, 0011, 0110 and 0111 are the restricted-read codes, and each sets rd=1, mro=1, wr=0, ux=0, px=0. tl1 equals code bit 0 and tl0 equals code bit 2. This gives 0010 no qualifier, 0011 tl1, 0110 tl0, and 0111 both.
- R5: Code 0100 is write-only: wr=1 and every other flag is 0.
- R6: Codes 10xx are read-only: rd=1, wr=0, mro=tl0=tl1=0. ux equals code bit 0 and px equals code bit 1.
- R7: Codes 11xx set rd=1 and wr=1, with ux and px taken from code bits 0 and 1 as in R6, and mro=tl0=tl1=0.
- R8: While `pie_en` is 0, `perm_out` equals `direct_perm` regardless of table contents and index.
- R9: A write loads the whole table at the next rising edge. A lookup in the same cycle as the write returns the decode of the old contents.
- R10: `inval_pulse` is high in exactly the cycle after each cycle with `wr_en` high, and low otherwise. A write made while `pie_en` is 0 still updates the table and still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_data | input | 64 | New table contents |
| pie_en | input | 1 | Indirection mechanism enable |
| lookup_idx | input | 4 | Entry index from the descriptor |
| direct_perm | input | 7 | Flags used when the mechanism is off |
| perm_out | output | 7 | Resulting access flags |
| inval_pulse | output | 1 | One-cycle invalidate after a write |

## Verification
A table write and a lookup can fall in the same cycle. In that cycle the lookup must return the decode of the old entry, and the new entry must appear one cycle later, together with the invalidate pulse. The bench provokes this by writing while holding the index steady on an entry whose code changes. It also writes back-to-back, and it writes while the mechanism is disabled. A cycle-accurate behavioural model, updated only at the clock edge, judges the flags and the pulse on every cycle.

// File: rtl/s2_perm_pkg.sv
package s2_perm_pkg;
  localparam int CODE_W = 4;
  localparam int FLAG_W = 7;
  localparam int F_RD   = 0;
  localparam int F_WR   = 1;
  localparam int F_UX   = 2;
  localparam int F_PX   = 3;
  localparam int F_MRO  = 4;
  localparam int F_TL0  = 5;
  localparam int F_TL1  = 6;

  // Turn one 4-bit permission code into the flag vector.
  function automatic logic [FLAG_W-1:0] decode_code(input logic [CODE_W-1:0] c);
    logic [FLAG_W-1:0] f;
    f = '0;
    casez (c)
      4'b1???: begin
        f[F_RD] = 1'b1;
        f[F_WR] = c[2];
        f[F_UX] = c[0];
        f[F_PX] = c[1];
      end
      4'b0100: f[F_WR] = 1'b1;
      4'b0?1?: begin
        f[F_RD]  = 1'b1;
        f[F_MRO] = 1'b1;
        f[F_TL0] = c[2];
        f[F_TL1] = c[0];
      end
      default: f = '0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/pir_table.sv
module pir_table #(
  parameter int ENTRIES = 16,
  parameter int CODE_W  = 4,
  localparam int TBL_W  = ENTRIES * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TBL_W-1:0] wr_data,
  output logic [TBL_W-1:0] tbl_q,
  output logic             inval_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q   <= '0;
      inval_q <= 1'b0;
    end else begin
      inval_q <= wr_en;
      if (wr_en) tbl_q <= wr_data;
    end
  end
endmodule

// File: rtl/pir_entry_sel.sv
module pir_entry_sel #(
  parameter int ENTRIES = 16,
  parameter int CODE_W  = 4,
  localparam int TBL_W  = ENTRIES * CODE_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [TBL_W-1:0]  tbl,
  input  logic [IDX_W-1:0]  idx,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] slot [ENTRIES];

  for (genvar m = 0; m < ENTRIES; m++) begin : g_slot
    assign slot[m] = tbl[m*CODE_W +: CODE_W];
  end

  assign code = slot[idx];
endmodule

// File: rtl/pir_flag_mux.sv
module pir_flag_mux
  import s2_perm_pkg::*;
(
  input  logic              pie_en,
  input  logic [CODE_W-1:0] code,
  input  logic [FLAG_W-1:0] direct_perm,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] decoded;

  always_comb begin
    decoded = decode_code(code);
    flags   = pie_en ? decoded : direct_perm;
  end
endmodule

// File: rtl/s2_perm_lookup.sv
module s2_perm_lookup
  import s2_perm_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int TBL_W  = ENTRIES * CODE_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TBL_W-1:0]  wr_data,
  input  logic              pie_en,
  input  logic [IDX_W-1:0]  lookup_idx,
  input  logic [FLAG_W-1:0] direct_perm,
  output logic [FLAG_W-1:0] perm_out,
  output logic              inval_pulse
);
  logic [TBL_W-1:0]  tbl_q;
  logic [CODE_W-1:0] sel_code;

  pir_table #(.ENTRIES(ENTRIES), .CODE_W(CODE_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tbl_q   (tbl_q),
    .inval_q (inval_pulse)
  );

  pir_entry_sel #(.ENTRIES(ENTRIES), .CODE_W(CODE_W)) u_sel (
    .tbl  (tbl_q),
    .idx  (lookup_idx),
    .code (sel_code)
  );

  pir_flag_mux u_mux (
    .pie_en      (pie_en),
    .code        (sel_code),
    .direct_perm (direct_perm),
    .flags       (perm_out)
  );
endmodule

// File: rtl/s2_perm_checker.sv
module s2_perm_checker
  import s2_perm_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int TBL_W  = ENTRIES * CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [TBL_W-1:0]  wr_data,
  input logic              pie_en,
  input logic [FLAG_W-1:0] direct_perm,
  input logic [FLAG_W-1:0] perm_out,
  input logic              inval_pulse,
  input logic [TBL_W-1:0]  tbl_q,
  input logic [CODE_W-1:0] sel_code
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (tbl_q == '0) && !inval_pulse);

  assert_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pie_en && (sel_code == 4'b0000 || sel_code == 4'b0001 || sel_code == 4'b0101)
    |-> perm_out == '0);

  assert_mro_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pie_en && (perm_out[F_TL0] || perm_out[F_TL1])
    |-> perm_out[F_MRO] && !perm_out[F_WR] && sel_code[3:1] != 3'b000);

  assert_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pie_en && sel_code == 4'b0100 |-> perm_out == 7'b0000010);

  assert_read_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pie_en && sel_code[3:2] == 2'b11 |-> perm_out[F_RD] && perm_out[F_WR] && !perm_out[F_MRO]);

  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pie_en |-> perm_out == direct_perm);

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl_q == $past(wr_data));

  assert_inval_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> inval_pulse);

  assert_inval_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !inval_pulse);
endmodule

bind s2_perm_lookup s2_perm_checker #(.ENTRIES(ENTRIES)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .pie_en      (pie_en),
  .direct_perm (direct_perm),
  .perm_out    (perm_out),
  .inval_pulse (inval_pulse),
  .tbl_q       (tbl_q),
  .sel_code    (sel_code)
);

// File: tb/test_s2_perm_lookup.sv
module test_s2_perm_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        pie_en = 1'b0;
  logic [3:0]  lookup_idx = '0;
  logic [6:0]  direct_perm = '0;
  logic [6:0]  perm_out;
  logic        inval_pulse;

  int tests = 0;
  int fails = 0;

  int model_tbl [16];
  bit model_inval = 1'b0;

  always #10 clk = ~clk;

  s2_perm_lookup i_s2_perm_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pie_en(pie_en), .lookup_idx(lookup_idx), .direct_perm(direct_perm),
    .perm_out(perm_out), .inval_pulse(inval_pulse)
  );

  // Behavioural restatement of R3..R7, written as value ranges.
  function automatic logic [6:0] ref_flags(input int v);
    logic [6:0] r;
    r = '0;
    if (v >= 8) begin
      r[0] = 1;
      r[1] = (v >= 12);
      r[2] = (v % 2 == 1);
      r[3] = ((v / 2) % 2 == 1);
    end else if (v == 4) begin
      r[1] = 1;
    end else if (v == 2 || v == 3 || v == 6 || v == 7) begin
      r[0] = 1;
      r[4] = 1;
      r[5] = (v >= 6);
      r[6] = (v % 2 == 1);
    end
    return r;
  endfunction

  function automatic string code_tag(input int v);
    if (v >= 12) return "R7";
    if (v >= 8)  return "R6";
    if (v == 4)  return "R5";
    if (v == 2 || v == 3 || v == 6 || v == 7) return "R4";
    return "R3";
  endfunction

  // One cycle: drive at negedge, compare mid-low phase, advance model at posedge.
  task automatic step(input string phase, input bit we, input logic [63:0] wd,
                      input bit en, input int idx, input logic [6:0] dp);
    logic [6:0] exp_f;
    string tag;
    @(negedge clk);
    wr_en = we; wr_data = wd; pie_en = en; lookup_idx = idx[3:0]; direct_perm = dp;
    #5;
    if (en) begin
      exp_f = ref_flags(model_tbl[idx]);
      tag = code_tag(model_tbl[idx]);
    end else begin
      exp_f = dp;
      tag = "R8";
    end
    tests++;
    if (perm_out !== exp_f) begin
      fails++;
      $display("FAIL %s/%s idx=%0d perm_out actual=%b expected=%b", phase, tag, idx, perm_out, exp_f);
    end
    tests++;
    if (inval_pulse !== model_inval) begin
      fails++;
      $display("FAIL R10 (%s) inval_pulse actual=%b expected=%b", phase, inval_pulse, model_inval);
    end
    @(posedge clk);
    #1;
    model_inval = we;
    if (we) for (int m = 0; m < 16; m++) model_tbl[m] = int'(wd[m*4 +: 4]);
  endtask

  function automatic logic [63:0] pack_seq(input bit reverse);
    logic [63:0] d;
    for (int m = 0; m < 16; m++) d[m*4 +: 4] = reverse ? 4'(15 - m) : 4'(m);
    return d;
  endfunction

  initial begin
    for (int m = 0; m < 16; m++) model_tbl[m] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on every index
    for (int i = 0; i < 16; i++) step("R1", 0, '0, 1, i, 7'h7F);

    // R2: entry m holds code m, sweep all indices (covers R3..R7)
    step("R2", 1, pack_seq(0), 1, 0, '0);
    for (int i = 0; i < 16; i++) step("R2", 0, '0, 1, i, '0);
    // reversed placement
    step("R2", 1, pack_seq(1), 1, 5, '0);
    for (int i = 0; i < 16; i++) step("R2", 0, '0, 1, i, '0);

    // R8: disabled, direct bus passes through for many patterns
    for (int i = 0; i < 16; i++) step("R8", 0, '0, 0, i, 7'((i * 37) ^ 7'h55));

    // R10: write while disabled still updates and pulses
    step("R10", 1, {16{4'b0100}}, 0, 3, 7'h2A);
    step("R10", 0, '0, 1, 3, '0);
    step("R10", 0, '0, 1, 9, '0);

    // R9: write and lookup in the same cycle on a changing entry
    step("R9", 1, {16{4'b1111}}, 1, 7, '0);
    step("R9", 0, '0, 1, 7, '0);
    step("R9", 1, {16{4'b0001}}, 1, 7, '0);
    step("R9", 1, {16{4'b0110}}, 1, 7, '0);
    step("R9", 1, {16{4'b1001}}, 1, 7, '0);
    step("R9", 0, '0, 1, 7, '0);

    // Mixed pseudo-random writes and lookups
    begin
      logic [63:0] d;
      d = 64'hC3A5_1F0E_9B47_62D8;
      for (int k = 0; k < 60; k++) begin
        d = {d[62:0], d[63] ^ d[62] ^ d[60] ^ d[59]};
        step("R2", (k % 3 == 0), d, (k % 5 != 0), (k * 7) % 16, d[6:0]);
      end
    end
    step("R10", 0, '0, 1, 0, '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule